// File: doc/BRIEF.md
# Non-Cacheable Bus Retry Sequencer

This block carries one processor read or write to the system bus and runs it to a final outcome without further help from the processor. When a request is accepted, the block stores the address, the write data, the direction and a flag that marks cacheable space. It then asks the bus arbiter for the bus. Once the bus is granted, it drives a four-cycle bus transaction.

In the third cycle of each transaction the block samples a retry indication from the responder. For non-cacheable space, a retry makes the block release the bus for one cycle and ask for it again. It then reissues exactly the same transaction. There is no limit on how many times this can happen. For cacheable space, a retry is not allowed and ends the request with an error.

If no retry arrives, the acknowledge is sampled in the fourth cycle. An acknowledge completes the request; a missing acknowledge ends it with an error. The processor sees one done pulse per request, with an error flag beside it when the request failed. A saturating count of the retries seen by the current request is shown for observation.

Top module: `nc_retry_seq`

## Requirements
- R1: After reset, req_ready is 1 and bus_req, bus_cyc, done, err and retry_cnt are all 0.
- R2: When req_valid and req_ready are both 1 at a clock edge, the request is accepted. From the next cycle, req_ready is 0 and bus_req is 1.
- R3: bus_cyc rises only in the cycle after bus_gnt was sampled 1 while bus_req was 1. An attempt that is not retried keeps bus_cyc high for exactly 4 cycles; a retried attempt keeps it high for 3 cycles.
- R4: bus_retry is sampled only in the third bus_cyc cycle, and bus_ack only in the fourth. At any other time both inputs have no effect on the outcome.
- R5: A retry in non-cacheable space (req_cacheable=0) drops bus_req for exactly one cycle. bus_req is then raised again and the same transaction is reissued, without a new request from the processor.
- R6: Any number of consecutive retries is allowed. retry_cnt (CNT_W bits) rises by one per retry and saturates at 2^CNT_W-1.
- R7: A retry in cacheable space (req_cacheable=1) ends the request after a single attempt, with done=1 and err=1.
- R8: An acknowledge in the fourth cycle gives a done pulse with err=0. For a read (req_write=0), rdata equals the bus_rdata value sampled in that fourth cycle.
- R9: A missing acknowledge in the fourth cycle gives done=1 and err=1 in the same cycle.
- R10: retry_cnt returns to 0 in the cycle after a new request is accepted.
- R11: bus_addr, bus_wdata and bus_write keep the values accepted with the request until done.
- R12: done and err are pulses of one cycle. err is never 1 without done, and req_ready returns to 1 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | 1 = target is cacheable space |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| rdata | output | DATA_W | Read data captured on a successful read |
| retry_cnt | output | CNT_W | Saturating retry count of the current request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cyc | output | 1 | High during each cycle of a bus transaction |
| bus_write | output | 1 | Held transaction direction |
| bus_addr | output | ADDR_W | Held transaction address |
| bus_wdata | output | DATA_W | Held write data |
| bus_rdata | input | DATA_W | Read data from the responder |
| bus_retry | input | 1 | Responder retry indication |
| bus_ack | input | 1 | Responder acknowledge |

## Verification
A sequencer that has lost track of the cycle count would sample retry or acknowledge in the wrong cycle. That shows up within one attempt: the bus_cyc length is wrong, or a noise pulse on bus_retry or bus_ack changes the outcome. A wrong decision after a retry shows within a few cycles. Examples are reissuing in cacheable space, failing to drop bus_req, or a miscounted or unsaturated retry_cnt; the per-request attempt and release counts at done expose each of these. Corrupted held state appears as a bus_addr, bus_wdata or bus_write change during any attempt, or as wrong read data at done.

// File: rtl/nc_retry_pkg.sv
package nc_retry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_C1,
    ST_C2,
    ST_C3,
    ST_C4,
    ST_REL,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/nc_req_hold.sv
module nc_req_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              in_write,
  input  logic              in_cacheable,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              hold_write,
  output logic              hold_cacheable,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_write     <= 1'b0;
      hold_cacheable <= 1'b0;
      hold_addr      <= '0;
      hold_wdata     <= '0;
    end else if (load) begin
      hold_write     <= in_write;
      hold_cacheable <= in_cacheable;
      hold_addr      <= in_addr;
      hold_wdata     <= in_wdata;
    end
  end
endmodule

// File: rtl/nc_sat_cnt.sv
module nc_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nc_seq_fsm.sv
module nc_seq_fsm
  import nc_retry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic cacheable,
  input  logic bus_gnt,
  input  logic bus_retry,
  input  logic bus_ack,
  output logic load,
  output logic cnt_inc,
  output logic capture,
  output logic req_ready,
  output logic bus_req,
  output logic bus_cyc,
  output logic done,
  output logic err
);
  seq_state_t state, nxt;
  logic       nxt_err;

  always_comb begin
    nxt     = state;
    nxt_err = 1'b0;
    load    = 1'b0;
    cnt_inc = 1'b0;
    capture = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin nxt = ST_ARB; load = 1'b1; end
      ST_ARB:  if (bus_gnt) nxt = ST_C1;
      ST_C1:   nxt = ST_C2;
      ST_C2:   nxt = ST_C3;
      ST_C3: begin
        if (bus_retry) begin
          if (cacheable) begin
            nxt     = ST_FIN;
            nxt_err = 1'b1;
          end else begin
            nxt     = ST_REL;
            cnt_inc = 1'b1;
          end
        end else begin
          nxt = ST_C4;
        end
      end
      ST_C4: begin
        nxt = ST_FIN;
        if (bus_ack) capture = 1'b1;
        else         nxt_err = 1'b1;
      end
      ST_REL:  nxt = ST_ARB;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      bus_req   <= 1'b0;
      bus_cyc   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      state     <= nxt;
      req_ready <= (nxt == ST_IDLE);
      bus_req   <= (nxt inside {ST_ARB, ST_C1, ST_C2, ST_C3, ST_C4});
      bus_cyc   <= (nxt inside {ST_C1, ST_C2, ST_C3, ST_C4});
      done      <= (nxt == ST_FIN);
      err       <= (nxt == ST_FIN) && nxt_err;
    end
  end
endmodule

// File: rtl/nc_retry_seq.sv
module nc_retry_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  retry_cnt,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cyc,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_retry,
  input  logic              bus_ack
);
  logic load, cnt_inc, capture, held_cacheable;

  nc_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .cacheable (held_cacheable),
    .bus_gnt   (bus_gnt),
    .bus_retry (bus_retry),
    .bus_ack   (bus_ack),
    .load      (load),
    .cnt_inc   (cnt_inc),
    .capture   (capture),
    .req_ready (req_ready),
    .bus_req   (bus_req),
    .bus_cyc   (bus_cyc),
    .done      (done),
    .err       (err)
  );

  nc_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk            (clk),
    .rst            (rst),
    .load           (load),
    .in_write       (req_write),
    .in_cacheable   (req_cacheable),
    .in_addr        (req_addr),
    .in_wdata       (req_wdata),
    .hold_write     (bus_write),
    .hold_cacheable (held_cacheable),
    .hold_addr      (bus_addr),
    .hold_wdata     (bus_wdata)
  );

  nc_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (load),
    .inc (cnt_inc),
    .cnt (retry_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture && !bus_write) begin
      rdata <= bus_rdata;
    end
  end
endmodule

// File: rtl/nc_retry_seq_chk.sv
module nc_retry_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic [CNT_W-1:0]  retry_cnt,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_cyc,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (bus_req && !req_ready));

  a_r10_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (retry_cnt == '0));

  a_r3_cyc_under_req: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> bus_req);

  a_r3_cyc_after_gnt: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cyc) |-> $past(bus_gnt));

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |->
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));

  a_r6_cnt_no_drop: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> (retry_cnt >= $past(retry_cnt)));

  a_r12_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));
endmodule

bind nc_retry_seq nc_retry_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .err       (err),
  .retry_cnt (retry_cnt),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_cyc   (bus_cyc),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/nc_retry_seq_tb.sv
module nc_retry_seq_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  typedef struct {
    logic              err;
    logic              write;
    logic [DATA_W-1:0] rdata;
    int                cnt;
    int                attempts;
    int                releases;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, done, err, bus_req, bus_cyc, bus_write;
  logic [DATA_W-1:0] rdata, bus_wdata;
  logic [CNT_W-1:0] retry_cnt;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_gnt = 1'b0, bus_retry = 1'b0, bus_ack = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;

  always #2 clk = ~clk;

  nc_retry_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cacheable(req_cacheable), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .retry_cnt(retry_cnt), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cyc(bus_cyc), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_retry(bus_retry),
    .bus_ack(bus_ack)
  );

  int n_tests = 0, n_fail = 0;
  exp_t sb_q[$];
  exp_t cur;

  int  cfg_rem = 0, cfg_gdelay = 0;
  logic cfg_ack = 1'b1, cfg_noise = 1'b0;
  int  phase = 0, gcnt = 0, attempts = 0, releases = 0, bad_len = 0, bad_hold = 0, bad_gnt = 0;
  logic prev_cyc = 1'b0, prev_gnt = 1'b0, retried = 1'b0;

  function automatic logic [DATA_W-1:0] resp_data(input logic [ADDR_W-1:0] a);
    return DATA_W'({a, ~a}) ^ 64'h5A5A_0F0F_3C3C_9696;
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder, arbiter and scoreboard monitor in one process per negedge
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_cyc && !prev_cyc) begin
        attempts++;
        retried = 1'b0;
        if (!prev_gnt) bad_gnt++;
      end
      if (!bus_cyc && prev_cyc) begin
        if (phase != (retried ? 3 : 4)) bad_len++;
      end
      phase = bus_cyc ? (prev_cyc ? phase + 1 : 1) : 0;
      if (bus_cyc && (bus_addr != cur.addr || bus_write != cur.write ||
                      (cur.write && bus_wdata != cur.wdata))) bad_hold++;
      if (!req_ready && !bus_req && !done) releases++;

      bus_retry = 1'b0;
      if (phase == 3 && cfg_rem > 0) begin
        bus_retry = 1'b1;
        cfg_rem--;
        retried = 1'b1;
      end else if (phase != 3) begin
        bus_retry = cfg_noise;
      end
      bus_ack   = (phase == 4) ? cfg_ack : cfg_noise;
      bus_rdata = (phase == 4) ? resp_data(bus_addr) : ~resp_data(bus_addr);

      if (bus_req && !bus_cyc) begin
        gcnt++;
        bus_gnt = (gcnt > cfg_gdelay);
      end else begin
        gcnt = 0;
        bus_gnt = bus_cyc;
      end
      prev_gnt = bus_gnt;
      prev_cyc = bus_cyc;

      if (done) begin
        if (sb_q.size() == 0) begin
          check("R12 unexpected done", 1'b0, 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check("R7/R8/R9 err", err == e.err, err, e.err);
          check("R6 retry_cnt", retry_cnt == e.cnt, retry_cnt, e.cnt);
          check("R5 attempts", attempts == e.attempts, attempts, e.attempts);
          check("R5 releases", releases == e.releases, releases, e.releases);
          check("R3 bus_cyc length", bad_len == 0, bad_len, 0);
          check("R3 cyc before gnt", bad_gnt == 0, bad_gnt, 0);
          check("R11 held fields", bad_hold == 0, bad_hold, 0);
          if (!e.write && !e.err)
            check("R8 rdata", rdata == e.rdata, rdata, e.rdata);
        end
      end
    end
  end

  task automatic issue(input logic wr, input logic cach, input logic [ADDR_W-1:0] a,
                       input int retries, input logic ack, input logic noise, input int gdelay);
    exp_t e;
    while (!req_ready) @(negedge clk);
    e.write = wr; e.addr = a; e.wdata = {a, a} ^ 64'h1234_5678_9ABC_DEF0;
    e.rdata = resp_data(a);
    if (cach && retries > 0) begin
      e.err = 1'b1; e.cnt = 0; e.attempts = 1; e.releases = 0;
    end else begin
      e.err = !ack; e.cnt = (retries > CMAX) ? CMAX : retries;
      e.attempts = retries + 1; e.releases = retries;
    end
    cur = e;
    cfg_rem = retries; cfg_ack = ack; cfg_noise = noise; cfg_gdelay = gdelay;
    attempts = 0; releases = 0; bad_len = 0; bad_hold = 0; bad_gnt = 0;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_cacheable = cach;
    req_addr = a; req_wdata = e.wdata;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = '0; req_write = ~wr;
    check("R2 accept ready", req_ready == 1'b0, req_ready, 0);
    check("R2 accept bus_req", bus_req == 1'b1, bus_req, 1);
    check("R10 cnt cleared", retry_cnt == '0, retry_cnt, 0);
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R12 ready after done", req_ready == 1'b1 && done == 1'b0, {req_ready, done}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset ready", req_ready == 1'b1, req_ready, 1);
    check("R1 reset bus", bus_req == 1'b0 && bus_cyc == 1'b0, {bus_req, bus_cyc}, 0);
    check("R1 reset done/err", done == 1'b0 && err == 1'b0, {done, err}, 0);
    check("R1 reset cnt", retry_cnt == '0, retry_cnt, 0);
    issue(1'b0, 1'b0, 32'h0000_1000, 0,  1'b1, 1'b0, 0); // R8 plain read
    issue(1'b1, 1'b0, 32'h0000_2040, 2,  1'b1, 1'b0, 3); // R5 write, grant delay
    issue(1'b0, 1'b0, 32'h0000_30C0, 1,  1'b0, 1'b0, 0); // R9 no ack after retry
    issue(1'b0, 1'b1, 32'h8000_0100, 1,  1'b1, 1'b0, 1); // R7 cacheable retry
    issue(1'b1, 1'b1, 32'h8000_0200, 0,  1'b1, 1'b0, 0); // cacheable ok
    issue(1'b0, 1'b0, 32'h0000_4400, 0,  1'b1, 1'b1, 0); // R4 noise ignored
    issue(1'b0, 1'b0, 32'h0000_5500, 17, 1'b1, 1'b0, 0); // R6 saturation
    issue(1'b1, 1'b0, 32'h0000_6600, 3,  1'b1, 1'b1, 2); // R4 noise with retries
    issue(1'b0, 1'b0, 32'h0000_7700, 0,  1'b0, 1'b1, 0); // R4 noise, no ack -> R9
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule